// File: doc/BRIEF.md
# Four-Lane Byte Butterfly Permuter

This block reorders the four byte lanes of a 32-bit packed word. The word passes through three columns of two-input exchange switches. The first column works on adjacent lanes, the middle column on lanes two apart, and the last column on adjacent lanes again. Six control bits set the switches, and these three columns together can produce any ordering of the four lanes. After the network, a per-lane enable forces chosen output bytes to zero, so that the leading or trailing partial groups of a loop can be blanked.

The six control bits are not carried with the data. They are read from a 32-entry table, and the entry is picked by the destination register index of the operation. Software loads the table through a synchronous write port. Every entry clears to zero at reset, and zero is the pass-through ordering. Both the data path and the table read path are combinational, so only the table itself holds state.

Top module: `lane_butterfly_permuter`

## Requirements
- R1: Lane i is data bits [8i+7:8i]. With a control word of zero, data_out equals data_in.
- R2: In the first column, control bit 0 exchanges lanes 0 and 1, and bit 1 exchanges lanes 2 and 3. A set bit means exchange.
- R3: In the middle column, control bit 2 exchanges lanes 0 and 2, and bit 3 exchanges lanes 1 and 3.
- R4: In the last column, bit 4 exchanges lanes 0 and 1, and bit 5 exchanges lanes 2 and 3. The columns act in the order first, middle, last.
- R5: Every output is a reordering of the input bytes. Across all 64 control words, all 24 orderings of the four lanes occur.
- R6: The control table has 32 entries, and every entry is zero after reset.
- R7: A write with cfg_we high stores cfg_data at cfg_addr on the next rising clock edge. The value is not visible before that edge. The entry addressed by dst_idx sets the network combinationally.
- R8: A write to one table entry leaves every other entry unchanged.
- R9: When lane_en[i] is low, output byte i is zero. The mask applies to output positions after the network. Enabled bytes carry the network result.
- R10: data_out follows a change on data_in or lane_en with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the control table |
| rst_n | input | 1 | Active-low asynchronous reset; clears the table |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | 5 | Table entry to write |
| cfg_data | input | 6 | Control word to store |
| dst_idx | input | 5 | Destination index that selects the active entry |
| lane_en | input | 4 | Per-output-lane enable; a low bit zeroes that byte |
| data_in | input | 32 | Packed four-byte input word |
| data_out | output | 32 | Reordered and masked word |

## Verification
The bench first uses single-bit control words on a word with distinct bytes, so that each switch is checked alone and a wiring or bit-order error cannot hide behind another switch. It then goes through all 64 control words on the same word. Each result is compared with a model that applies the exchanges in sequence, and the distinct orderings seen are counted. Table tests write one entry and read its neighbours, which separates address decoding faults from data faults. Mask patterns combined with a non-trivial ordering show whether the mask is applied to output positions or to input positions.

// File: rtl/bperm_pkg.sv
package bperm_pkg;
  localparam int LANES     = 4;
  localparam int STAGES    = 3;
  localparam int SEL_PER   = 2;
  localparam int CTRL_BITS = STAGES * SEL_PER;

  // Distance between the two lanes of a switch in a given column.
  function automatic int stage_stride(input int stage);
    return (stage == 1) ? 2 : 1;
  endfunction

  // Lower lane of switch p in a column of the given stride.
  function automatic int pair_low(input int stride, input int p);
    return (stride == 1) ? 2 * p : p;
  endfunction
endpackage

// File: rtl/bperm_ctrl_table.sv
module bperm_ctrl_table #(
  parameter int ENTRIES = 32,
  parameter int DATA_W  = 6,
  localparam int ADDR_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] entry_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) entry_q[i] <= '0;
    end else if (wr_en && (int'(wr_addr) < ENTRIES)) begin
      entry_q[wr_addr] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_addr) < ENTRIES) rd_data = entry_q[rd_addr];
  end
endmodule

// File: rtl/bperm_swap_column.sv
module bperm_swap_column #(
  parameter int LANE_W = 8,
  parameter int STRIDE = 1,
  localparam int LANES  = bperm_pkg::LANES,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic [1:0]        sel,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  for (genvar p = 0; p < 2; p++) begin : g_pair
    localparam int LO = bperm_pkg::pair_low(STRIDE, p);
    localparam int HI = LO + STRIDE;
    logic [LANE_W-1:0] a, b;
    assign a = din[LO*LANE_W +: LANE_W];
    assign b = din[HI*LANE_W +: LANE_W];
    assign dout[LO*LANE_W +: LANE_W] = sel[p] ? b : a;
    assign dout[HI*LANE_W +: LANE_W] = sel[p] ? a : b;
  end
endmodule

// File: rtl/bperm_lane_mask.sv
module bperm_lane_mask #(
  parameter int LANE_W = 8,
  localparam int LANES  = bperm_pkg::LANES,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic [LANES-1:0]  en,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign dout[i*LANE_W +: LANE_W] = en[i] ? din[i*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/lane_butterfly_permuter.sv
module lane_butterfly_permuter #(
  parameter int LANE_W  = 8,
  parameter int NUM_DST = 32,
  localparam int LANES  = bperm_pkg::LANES,
  localparam int CTRL_W = bperm_pkg::CTRL_BITS,
  localparam int STAGES = bperm_pkg::STAGES,
  localparam int ADDR_W = $clog2(NUM_DST),
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CTRL_W-1:0] cfg_data,
  input  logic [ADDR_W-1:0] dst_idx,
  input  logic [LANES-1:0]  lane_en,
  input  logic [WORD_W-1:0] data_in,
  output logic [WORD_W-1:0] data_out
);
  logic [CTRL_W-1:0] ctrl_sel;
  logic [WORD_W-1:0] net_out;
  logic [WORD_W-1:0] col_w [STAGES+1];

  bperm_ctrl_table #(.ENTRIES(NUM_DST), .DATA_W(CTRL_W)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr),
    .wr_data(cfg_data), .rd_addr(dst_idx), .rd_data(ctrl_sel)
  );

  assign col_w[0] = data_in;

  for (genvar s = 0; s < STAGES; s++) begin : g_col
    bperm_swap_column #(
      .LANE_W(LANE_W), .STRIDE(bperm_pkg::stage_stride(s))
    ) u_col (
      .sel(ctrl_sel[2*s +: 2]), .din(col_w[s]), .dout(col_w[s+1])
    );
  end

  assign net_out = col_w[STAGES];

  bperm_lane_mask #(.LANE_W(LANE_W)) u_mask (
    .en(lane_en), .din(net_out), .dout(data_out)
  );
endmodule

// File: rtl/bperm_checker.sv
module bperm_checker #(
  parameter int LANE_W  = 8,
  parameter int NUM_DST = 32,
  localparam int LANES  = 4,
  localparam int CTRL_W = 6,
  localparam int ADDR_W = $clog2(NUM_DST),
  localparam int WORD_W = LANES * LANE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [CTRL_W-1:0] cfg_data,
  input logic [ADDR_W-1:0] dst_idx,
  input logic [LANES-1:0]  lane_en,
  input logic [WORD_W-1:0] data_in,
  input logic [WORD_W-1:0] data_out,
  input logic [CTRL_W-1:0] ctrl_sel,
  input logic [WORD_W-1:0] net_out
);
  assert_identity_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_sel == '0) |-> (net_out == data_in));

  assert_bits_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(net_out) == $countones(data_in));

  assert_write_seen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_we) && $stable(dst_idx) && ($past(cfg_addr) == dst_idx))
    |-> (ctrl_sel == $past(cfg_data)));

  assert_other_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(dst_idx) && !($past(cfg_we) && ($past(cfg_addr) == dst_idx)))
    |-> $stable(ctrl_sel));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assert_lane_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_en[i] |-> (data_out[i*LANE_W +: LANE_W] == '0));
    assert_lane_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lane_en[i] |-> (data_out[i*LANE_W +: LANE_W] == net_out[i*LANE_W +: LANE_W]));
  end
endmodule

bind lane_butterfly_permuter bperm_checker #(.LANE_W(LANE_W), .NUM_DST(NUM_DST)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
  .dst_idx(dst_idx), .lane_en(lane_en), .data_in(data_in), .data_out(data_out),
  .ctrl_sel(ctrl_sel), .net_out(net_out)
);

// File: tb/lane_butterfly_permuter_tb.sv
module lane_butterfly_permuter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [5:0]  cfg_data = '0;
  logic [4:0]  dst_idx = '0;
  logic [3:0]  lane_en = 4'hF;
  logic [31:0] data_in = '0;
  logic [31:0] data_out;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lane_butterfly_permuter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .dst_idx(dst_idx), .lane_en(lane_en), .data_in(data_in), .data_out(data_out)
  );

  // Reference: apply the six exchanges one after another on a byte array.
  function automatic logic [31:0] ref_perm(input logic [5:0] c, input logic [31:0] w);
    logic [7:0] b [4];
    logic [7:0] t;
    int lo [6] = '{0, 2, 0, 1, 0, 2};
    int hi [6] = '{1, 3, 2, 3, 1, 3};
    for (int i = 0; i < 4; i++) b[i] = w[8*i +: 8];
    for (int k = 0; k < 6; k++)
      if (c[k]) begin t = b[lo[k]]; b[lo[k]] = b[hi[k]]; b[hi[k]] = t; end
    return {b[3], b[2], b[1], b[0]};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic write_entry(input logic [4:0] a, input logic [5:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset;
    data_in = 32'h44332211; lane_en = 4'hF;
    for (int e = 0; e < 32; e += 7) begin
      dst_idx = 5'(e); #1;
      check("R6 reset entry", data_out, 32'h44332211);
    end
    dst_idx = 5'd31; #1;
    check("R1 identity", data_out, data_in);
  endtask

  task automatic t_single_bits;
    data_in = 32'hDDCCBBAA; dst_idx = 5'd3;
    write_entry(5'd3, 6'b000001); #1; check("R2 bit0", data_out, 32'hDDCCAABB);
    write_entry(5'd3, 6'b000010); #1; check("R2 bit1", data_out, 32'hCCDDBBAA);
    write_entry(5'd3, 6'b000100); #1; check("R3 bit2", data_out, 32'hDDAABBCC);
    write_entry(5'd3, 6'b001000); #1; check("R3 bit3", data_out, 32'hBBCCDDAA);
    write_entry(5'd3, 6'b010000); #1; check("R4 bit4", data_out, 32'hDDCCAABB);
    write_entry(5'd3, 6'b100000); #1; check("R4 bit5", data_out, 32'hCCDDBBAA);
    write_entry(5'd3, 6'b000101); #1; check("R4 order", data_out, 32'hDDBBAACC);
  endtask

  task automatic t_all_words;
    bit seen [256];
    int distinct = 0;
    logic [7:0] key;
    data_in = 32'h03020100; dst_idx = 5'd9;
    for (int c = 0; c < 64; c++) begin
      write_entry(5'd9, 6'(c)); #1;
      check("R5 model", data_out, ref_perm(6'(c), data_in));
      key = {data_out[25:24], data_out[17:16], data_out[9:8], data_out[1:0]};
      if (!seen[key]) begin seen[key] = 1'b1; distinct++; end
    end
    check("R5 orderings", 32'(distinct), 32'd24);
  endtask

  task automatic t_write_timing;
    data_in = 32'h87654321; dst_idx = 5'd12;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'd12; cfg_data = 6'b001100;
    #1; check("R7 before edge", data_out, 32'h87654321);
    @(negedge clk); cfg_we = 1'b0; #1;
    check("R7 after edge", data_out, ref_perm(6'b001100, data_in));
    dst_idx = 5'd13; #1;
    check("R7 read select", data_out, ref_perm(6'd0, data_in));
  endtask

  task automatic t_isolation;
    data_in = 32'hA1B2C3D4;
    write_entry(5'd20, 6'b101010);
    write_entry(5'd21, 6'b010101);
    dst_idx = 5'd19; #1; check("R8 below", data_out, data_in);
    dst_idx = 5'd20; #1; check("R8 kept", data_out, ref_perm(6'b101010, data_in));
    dst_idx = 5'd21; #1; check("R8 newer", data_out, ref_perm(6'b010101, data_in));
    dst_idx = 5'd22; #1; check("R8 above", data_out, data_in);
  endtask

  task automatic t_mask;
    logic [31:0] p;
    data_in = 32'h44332211; dst_idx = 5'd20;
    p = ref_perm(6'b101010, data_in);
    for (int m = 0; m < 16; m += 5) begin
      lane_en = 4'(m); #1;
      check("R9 mask", data_out,
            p & {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}});
    end
    lane_en = 4'b1110; #1;
    check("R9 leading", data_out, p & 32'hFFFFFF00);
    lane_en = 4'b0001; #1;
    check("R9 trailing", data_out, p & 32'h000000FF);
    lane_en = 4'hF;
  endtask

  task automatic t_comb;
    @(posedge clk); #2;
    dst_idx = 5'd21;
    data_in = 32'h0F1E2D3C; #1;
    check("R10 data", data_out, ref_perm(6'b010101, 32'h0F1E2D3C));
    lane_en = 4'b0110; #1;
    check("R10 enable", data_out, ref_perm(6'b010101, 32'h0F1E2D3C) & 32'h00FFFF00);
    lane_en = 4'hF;
  endtask

  initial begin
    #1;
    check("R6 held in reset", data_out, 32'h00000000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single_bits();
    t_all_words();
    t_write_timing();
    t_isolation();
    t_mask();
    t_comb();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule